// File: doc/BRIEF.md
# Bus Cycle Breakpoint Comparator

This block watches a processor bus and flags a hardware breakpoint when a bus cycle begins at a programmed address with programmed access attributes. It looks only in the clock where the transfer-start strobe is asserted. In that clock it compares the cycle's address, its read/write direction, its function code and its transfer size against two software-written registers. When everything agrees, it drives an active-low breakpoint pulse. The pulse is meant to be wired to a level-7, non-maskable interrupt request.

The block compares only at the start of a cycle, so the later beats of a burst never raise a breakpoint. A breakpoint-acknowledge cycle from the processor is never matched. The block also has no way to terminate a bus cycle, so such a cycle runs on until the system bus-timeout logic ends it with a transfer error.

Each comparison field can be masked so that it always agrees. A global enable gates the whole function. The enable is cleared at reset.

Top module: `bkpt_match_unit`

## Requirements
- R1: A comparison is made only in a clock where `ts_n_i` is low. When `ts_n_i` is high, any address or attribute values leave `bkpt_n_o` high.
- R2: The beats of a burst that follow the strobe clock (with `ts_n_i` high) are not compared, even when their address and attributes equal the programmed values.
- R3: With no field masked, a breakpoint needs all four fields to agree: the address equals the address register, `rw_i` agrees with the direction selector, `fc_i` equals the function-code field and `siz_i` equals the size field. A difference in any single one of them leaves `bkpt_n_o` high.
- R4: `bkpt_n_o` is active-low and registered. It goes low in the clock that follows the matching strobe clock and lasts exactly one clock.
- R5: A cycle with `kind_i` = 2'b11 (breakpoint acknowledge) never produces a breakpoint, whatever the masks and field values are. The block has no termination output.
- R6: Control bit 0 is the enable. It reads 0 after reset. While it is 0, `bkpt_n_o` stays high.
- R7: Control bit 2 masks direction, bit 5 masks size, bit 9 masks function code and bit 10 masks address. A masked field always agrees.
- R8: A register write in the same clock as a strobe affects only strobes in later clocks. The strobe in that clock uses the old values.
- R9: A write with `reg_sel_i` = 0 loads the address register from `reg_wdata_i`. A write with `reg_sel_i` = 1 loads the control register from `reg_wdata_i[10:0]`, with the size value in bits 4:3 and the function-code value in bits 8:6.
- R10: Control bit 1 selects the direction to match: 1 matches reads (`rw_i` = 1), 0 matches writes (`rw_i` = 0).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ts_n_i | input | 1 | Transfer-start strobe, active low |
| addr_i | input | 32 | Bus cycle address |
| rw_i | input | 1 | Direction, 1 = read, 0 = write |
| fc_i | input | 3 | Function code of the access |
| siz_i | input | 2 | Transfer size code |
| kind_i | input | 2 | Cycle kind, 2'b11 = breakpoint acknowledge |
| reg_we_i | input | 1 | Register write strobe |
| reg_sel_i | input | 1 | Register select, 0 = address, 1 = control |
| reg_wdata_i | input | 32 | Register write data |
| bkpt_n_o | output | 1 | Breakpoint pulse, active low |

## Verification
Fully matching strobed cycles are compared against cycles that differ in exactly one field (address, direction, function code or size). These show that every field takes part in the decision. Matching values presented without the strobe, and as burst beats after a non-matching strobe, separate strobe-qualified comparison from level-sensitive comparison. Masked setups, acknowledge cycles and a disabled unit test each gate on its own. A register write made in the same clock as a strobe shows whether the comparison used the old register values or the new ones.

// File: rtl/bkpt_pkg.sv
package bkpt_pkg;

    localparam int FC_W   = 3;
    localparam int SIZ_W  = 2;
    localparam int KIND_W = 2;

    localparam logic [KIND_W-1:0] KIND_ACK = 2'b11;
    localparam logic SEL_ADDR = 1'b0;
    localparam logic SEL_CTRL = 1'b1;

    // Control layout, LSB first: en[0] rw_val[1] rw_ign[2] siz_val[4:3]
    // siz_ign[5] fc_val[8:6] fc_ign[9] addr_ign[10]
    typedef struct packed {
        logic             addr_ign;
        logic             fc_ign;
        logic [FC_W-1:0]  fc_val;
        logic             siz_ign;
        logic [SIZ_W-1:0] siz_val;
        logic             rw_ign;
        logic             rw_val;
        logic             en;
    } ctrl_t;

    localparam int CTRL_W = $bits(ctrl_t);

endpackage

// File: rtl/bkpt_regs.sv
module bkpt_regs
    import bkpt_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we_i,
    input  logic              sel_i,
    input  logic [ADDR_W-1:0] wdata_i,
    output logic [ADDR_W-1:0] bk_addr_o,
    output ctrl_t             ctrl_o
);

    typedef struct packed {
        logic [ADDR_W-1:0] addr;
        ctrl_t             ctrl;
    } regs_t;

    regs_t regs_d, regs_q;

    always_comb begin
        regs_d = regs_q;
        if (we_i) begin
            if (sel_i == SEL_CTRL) begin
                regs_d.ctrl = ctrl_t'(wdata_i[CTRL_W-1:0]);
            end else begin
                regs_d.addr = wdata_i;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            regs_q <= '0;
        end else begin
            regs_q <= regs_d;
        end
    end

    assign bk_addr_o = regs_q.addr;
    assign ctrl_o    = regs_q.ctrl;

    // R9: address write lands one edge later
    p_addr_write_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (we_i && sel_i == SEL_ADDR) |=> (bk_addr_o == $past(wdata_i)));

    // R9: control write lands one edge later
    p_ctrl_write_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (we_i && sel_i == SEL_CTRL) |=> (ctrl_o == $past(wdata_i[CTRL_W-1:0])));

    // R6: enable is clear when reset is released
    p_reset_disable_r6: assert property (@(posedge clk)
        $rose(rst_n) |-> !ctrl_o.en);

endmodule

// File: rtl/bkpt_cmp.sv
module bkpt_cmp
    import bkpt_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input  logic              [ADDR_W-1:0] addr_i,
    input  logic                           rw_i,
    input  logic              [FC_W-1:0]   fc_i,
    input  logic              [SIZ_W-1:0]  siz_i,
    input  logic              [KIND_W-1:0] kind_i,
    input  logic              [ADDR_W-1:0] bk_addr_i,
    input  ctrl_t                          ctrl_i,
    output logic                           hit_o
);

    logic addr_ok, rw_ok, fc_ok, siz_ok, not_ack;

    always_comb begin
        addr_ok = ctrl_i.addr_ign || (addr_i == bk_addr_i);
        rw_ok   = ctrl_i.rw_ign   || (rw_i == ctrl_i.rw_val);
        fc_ok   = ctrl_i.fc_ign   || (fc_i == ctrl_i.fc_val);
        siz_ok  = ctrl_i.siz_ign  || (siz_i == ctrl_i.siz_val);
        not_ack = (kind_i != KIND_ACK);
        hit_o   = ctrl_i.en && not_ack && addr_ok && rw_ok && fc_ok && siz_ok;
    end

endmodule

// File: rtl/bkpt_match_unit.sv
module bkpt_match_unit
    import bkpt_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ts_n_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic              rw_i,
    input  logic [FC_W-1:0]   fc_i,
    input  logic [SIZ_W-1:0]  siz_i,
    input  logic [KIND_W-1:0] kind_i,
    input  logic              reg_we_i,
    input  logic              reg_sel_i,
    input  logic [ADDR_W-1:0] reg_wdata_i,
    output logic              bkpt_n_o
);

    typedef struct packed {
        logic bkpt_n;
    } state_t;

    state_t            st_d, st_q;
    logic [ADDR_W-1:0] bk_addr;
    ctrl_t             ctrl;
    logic              hit;

    bkpt_regs #(.ADDR_W(ADDR_W)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .we_i      (reg_we_i),
        .sel_i     (reg_sel_i),
        .wdata_i   (reg_wdata_i),
        .bk_addr_o (bk_addr),
        .ctrl_o    (ctrl)
    );

    bkpt_cmp #(.ADDR_W(ADDR_W)) u_cmp (
        .addr_i    (addr_i),
        .rw_i      (rw_i),
        .fc_i      (fc_i),
        .siz_i     (siz_i),
        .kind_i    (kind_i),
        .bk_addr_i (bk_addr),
        .ctrl_i    (ctrl),
        .hit_o     (hit)
    );

    // Compare is qualified by the start strobe only; burst beats never hit.
    always_comb begin
        st_d        = st_q;
        st_d.bkpt_n = !(!ts_n_i && hit);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{bkpt_n: 1'b1};
        end else begin
            st_q <= st_d;
        end
    end

    assign bkpt_n_o = st_q.bkpt_n;

    // R1: a pulse only follows a strobe clock
    p_strobe_only_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !bkpt_n_o |-> $past(!ts_n_i));

    // R4: no strobe now means no pulse next clock
    p_single_pulse_r4: assert property (@(posedge clk) disable iff (!rst_n)
        ts_n_i |=> bkpt_n_o);

    // R5: acknowledge cycles never raise a breakpoint
    p_ack_silent_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !bkpt_n_o |-> ($past(kind_i) != KIND_ACK));

    // R6: pulses need the enable
    p_enable_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !bkpt_n_o |-> $past(ctrl.en));

    // R3: unmasked address must agree with the register
    p_addr_agree_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!bkpt_n_o && !$past(ctrl.addr_ign)) |-> ($past(addr_i) == $past(bk_addr)));

endmodule

// File: tb/tb_bkpt_match_unit.sv
module tb_bkpt_match_unit;
    import bkpt_pkg::*;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ts_n_i = 1'b1;
    logic [31:0] addr_i = '0;
    logic        rw_i = 1'b0;
    logic [2:0]  fc_i = '0;
    logic [1:0]  siz_i = '0;
    logic [1:0]  kind_i = '0;
    logic        reg_we_i = 1'b0;
    logic        reg_sel_i = 1'b0;
    logic [31:0] reg_wdata_i = '0;
    logic        bkpt_n_o;

    int checks = 0;
    int fails  = 0;
    logic got;

    localparam logic [31:0] CTRL_BASIC = 32'h153; // en, read, siz 2, fc 5
    localparam logic [31:0] CTRL_ALLIG = 32'h625; // en, all fields masked
    localparam logic [31:0] CTRL_WRONLY = 32'h621; // en, match writes, others masked

    always #5 clk = ~clk;

    bkpt_match_unit dut (
        .clk(clk), .rst_n(rst_n), .ts_n_i(ts_n_i), .addr_i(addr_i),
        .rw_i(rw_i), .fc_i(fc_i), .siz_i(siz_i), .kind_i(kind_i),
        .reg_we_i(reg_we_i), .reg_sel_i(reg_sel_i), .reg_wdata_i(reg_wdata_i),
        .bkpt_n_o(bkpt_n_o)
    );

    task automatic chk(input string req, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: bkpt_n actual %b expected %b", req, act, exp);
        end
    endtask

    task automatic wr(input logic sel, input logic [31:0] data);
        @(negedge clk);
        reg_we_i = 1'b1; reg_sel_i = sel; reg_wdata_i = data;
        @(negedge clk);
        reg_we_i = 1'b0;
    endtask

    // one strobed cycle; result sampled one clock later
    task automatic strobe(input logic [31:0] a, input logic r, input logic [2:0] f,
                          input logic [1:0] s, input logic [1:0] k, output logic res);
        @(negedge clk);
        ts_n_i = 1'b0; addr_i = a; rw_i = r; fc_i = f; siz_i = s; kind_i = k;
        @(negedge clk);
        res = bkpt_n_o;
        ts_n_i = 1'b1; kind_i = 2'b00;
    endtask

    task automatic t_reset();
        chk("R6 reset", bkpt_n_o, 1'b1);
        strobe(32'h0, 1'b0, 3'd0, 2'd0, 2'b00, got);
        chk("R6 disabled after reset", got, 1'b1);
    endtask

    task automatic t_basic();
        wr(SEL_ADDR, 32'h0000_4000);
        wr(SEL_CTRL, CTRL_BASIC);
        strobe(32'h0000_4000, 1'b1, 3'd5, 2'd2, 2'b00, got);
        chk("R3 full match", got, 1'b0);
        @(negedge clk);
        chk("R4 one clock pulse", bkpt_n_o, 1'b1);
        strobe(32'h0000_4004, 1'b1, 3'd5, 2'd2, 2'b00, got);
        chk("R3 address differs", got, 1'b1);
        strobe(32'h0000_4000, 1'b1, 3'd4, 2'd2, 2'b00, got);
        chk("R3 fc differs", got, 1'b1);
        strobe(32'h0000_4000, 1'b1, 3'd5, 2'd1, 2'b00, got);
        chk("R3 size differs", got, 1'b1);
        strobe(32'h0000_4000, 1'b0, 3'd5, 2'd2, 2'b00, got);
        chk("R10 write vs read selector", got, 1'b1);
    endtask

    task automatic t_no_strobe();
        @(negedge clk);
        addr_i = 32'h0000_4000; rw_i = 1'b1; fc_i = 3'd5; siz_i = 2'd2;
        @(negedge clk);
        chk("R1 no strobe", bkpt_n_o, 1'b1);
        @(negedge clk);
        chk("R1 no strobe hold", bkpt_n_o, 1'b1);
    endtask

    task automatic t_burst();
        strobe(32'h0000_3FF0, 1'b1, 3'd5, 2'd2, 2'b00, got);
        chk("R2 burst head no match", got, 1'b1);
        for (int i = 0; i < 3; i++) begin
            addr_i = 32'h0000_4000;
            @(negedge clk);
            chk("R2 burst beat", bkpt_n_o, 1'b1);
        end
    endtask

    task automatic t_ack();
        strobe(32'h0000_4000, 1'b1, 3'd5, 2'd2, 2'b11, got);
        chk("R5 acknowledge cycle", got, 1'b1);
        wr(SEL_CTRL, CTRL_ALLIG);
        strobe(32'h0000_1234, 1'b0, 3'd0, 2'd0, 2'b11, got);
        chk("R5 acknowledge masked", got, 1'b1);
    endtask

    task automatic t_masks();
        wr(SEL_CTRL, CTRL_ALLIG);
        strobe(32'h0000_1234, 1'b0, 3'd0, 2'd0, 2'b00, got);
        chk("R7 all fields masked", got, 1'b0);
        strobe(32'hFFFF_0000, 1'b1, 3'd7, 2'd3, 2'b01, got);
        chk("R7 masked other values", got, 1'b0);
    endtask

    task automatic t_rw_sel();
        wr(SEL_CTRL, CTRL_WRONLY);
        strobe(32'h0000_0010, 1'b0, 3'd1, 2'd0, 2'b00, got);
        chk("R10 write selected write cycle", got, 1'b0);
        strobe(32'h0000_0010, 1'b1, 3'd1, 2'd0, 2'b00, got);
        chk("R10 write selected read cycle", got, 1'b1);
    endtask

    task automatic t_same_clk();
        wr(SEL_CTRL, CTRL_BASIC);
        @(negedge clk);
        ts_n_i = 1'b0; addr_i = 32'h0000_8000; rw_i = 1'b1; fc_i = 3'd5; siz_i = 2'd2;
        reg_we_i = 1'b1; reg_sel_i = SEL_ADDR; reg_wdata_i = 32'h0000_8000;
        @(negedge clk);
        got = bkpt_n_o;
        ts_n_i = 1'b1; reg_we_i = 1'b0;
        chk("R8 same clock uses old address", got, 1'b1);
        strobe(32'h0000_8000, 1'b1, 3'd5, 2'd2, 2'b00, got);
        chk("R8 R9 new address next strobe", got, 1'b0);
    endtask

    task automatic t_disable();
        wr(SEL_CTRL, CTRL_BASIC & ~32'h1);
        strobe(32'h0000_8000, 1'b1, 3'd5, 2'd2, 2'b00, got);
        chk("R6 enable cleared", got, 1'b1);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_basic();
        t_no_strobe();
        t_burst();
        t_ack();
        t_masks();
        t_rw_sel();
        t_same_clk();
        t_disable();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule